// File: doc/BRIEF.md
# Configurable Asynchronous Serial Receiver

This block receives characters on one asynchronous serial line. The line is sampled on a 16x oversampling tick that comes from a baud generator outside the block. The receiver finds a falling edge that could be a start bit and checks again at the middle of that bit to reject glitches. It then samples 7 or 8 data bits at their midpoints, least significant bit first, takes an optional parity bit and checks exactly one stop bit. The character is then copied into a receive buffer.

Live configuration inputs set four things: whether reception is on, how the parity bit is handled, the character length, and where error events are reported. An error event can go to the error interrupt or to the completion interrupt, but never to both. The parity, framing and overrun flags describe the most recent completed frame. They hold their value until the next frame completes. A one-cycle read strobe tells the block that the buffer has been read. Configuration is changed only while the line is idle or reception is off.

Top module: `serial_rx`

## Requirements
- R1: While `rxEnable` is 0, no start bit is detected and no data is shifted in. `rxData` keeps its value and neither interrupt pulses.
- R2: A 0 seen on the line at a tick starts a frame only if the line is still 0 eight ticks later. Otherwise the receiver returns to idle and reports nothing.
- R3: Data bits are sampled every 16 ticks at their midpoints, least significant bit first. They appear in `rxData` with the first received bit at bit 0.
- R4: With `charLen8` = 1, eight data bits are received. With `charLen8` = 0, seven are received and `rxData[7]` reads 0.
- R5: `paritySel` encoding: 00 means no parity bit. 01 means a parity bit is received but never checked, so `parityErr` stays 0. 10 means odd parity is checked. 11 means even parity is checked. For odd and even, a mismatch over the data bits and the parity bit sets `parityErr`.
- R6: Exactly one stop bit is sampled. If it is 0, `frameErr` is set for that frame.
- R7: At the end of every frame, `rxData` is loaded and the reported interrupt pulses for exactly one cycle, in the same clock edge as the load. After reset, `rxData`, both interrupts and all flags are 0.
- R8: If a frame completes while the previous character is still unread, `overrunErr` is set. A pulse on `bufRead` marks the buffer as read.
- R9: With `errToComplete` = 0, a frame that has any error (parity, framing or overrun) pulses only `errIrq`. `doneIrq` is suppressed.
- R10: With `errToComplete` = 1, a frame with an error pulses only `doneIrq`. `errIrq` is never raised.
- R11: Holding `rxEnable` low for 2 or more clock cycles abandons any frame in progress. After re-enabling, the next frame is received cleanly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rxEnable | input | 1 | Reception on (1) or off (0) |
| paritySel | input | 2 | Parity handling, encoded as in R5 |
| charLen8 | input | 1 | 1 selects 8 data bits, 0 selects 7 |
| errToComplete | input | 1 | 1 routes errors to `doneIrq`, 0 routes them to `errIrq` |
| sampleTick | input | 1 | One-cycle pulse at 16 times the bit rate |
| serialIn | input | 1 | Serial line, idle high |
| bufRead | input | 1 | One-cycle strobe: the buffer has been read |
| rxData | output | 8 | Receive buffer |
| doneIrq | output | 1 | Completion interrupt pulse |
| errIrq | output | 1 | Error interrupt pulse |
| parityErr | output | 1 | Parity error of the last frame |
| frameErr | output | 1 | Framing error of the last frame |
| overrunErr | output | 1 | Overrun of the last frame |

## Verification
The hardest state to reach from the ports is a frame cut off part way through by a short drop of the enable. The bench drives a start bit and a few data bits by hand and then pulls `rxEnable` low for three cycles while the receiver is still counting. It releases the line and sends a full frame, which must be received exactly, with a single completion pulse. Overrun is reached by sending two frames back to back without a read strobe. Glitch rejection is reached with a low pulse two ticks wide.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PARITY,
    ST_STOP
  } rxState_t;

  typedef struct packed {
    logic clear;     // reception off: drop partial frame
    logic shift;     // sample a data bit
    logic parLatch;  // sample the parity bit
    logic commit;    // sample stop bit, load buffer, report
  } rxStrobe_t;

endpackage

// File: rtl/serial_rx_ctrl.sv
module serial_rx_ctrl
  import serial_rx_pkg::*;
#(
  parameter int OVS = 16,
  parameter int DW  = 8
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      enable,
  input  logic      tick,
  input  logic      rxBit,
  input  logic      charLen8,
  input  logic      parityOn,
  output rxStrobe_t strobe
);

  localparam int CW = $clog2(OVS);
  localparam int BW = $clog2(DW + 1);
  localparam logic [CW-1:0] MID    = CW'(OVS / 2 - 1);
  localparam logic [CW-1:0] LAST   = CW'(OVS - 1);
  localparam logic [BW-1:0] LASTL  = BW'(DW - 1);
  localparam logic [BW-1:0] LASTS  = BW'(DW - 2);

  rxState_t      state;
  logic [CW-1:0] cnt;
  logic [BW-1:0] bitIdx;
  logic [BW-1:0] lastIdx;
  logic          atEnd;

  assign lastIdx = charLen8 ? LASTL : LASTS;
  assign atEnd   = (cnt == LAST);

  always_comb begin
    strobe          = '0;
    strobe.clear    = !enable;
    if (enable && tick) begin
      unique case (state)
        ST_DATA:   strobe.shift    = atEnd;
        ST_PARITY: strobe.parLatch = atEnd;
        ST_STOP:   strobe.commit   = atEnd;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !enable) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      bitIdx <= '0;
    end else if (tick) begin
      unique case (state)
        ST_IDLE: begin
          cnt <= '0;
          if (!rxBit) state <= ST_START;
        end
        ST_START: begin
          if (cnt == MID) begin
            cnt    <= '0;
            bitIdx <= '0;
            state  <= rxBit ? ST_IDLE : ST_DATA;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_DATA: begin
          cnt <= cnt + 1'b1;
          if (atEnd) begin
            bitIdx <= bitIdx + 1'b1;
            if (bitIdx == lastIdx) state <= parityOn ? ST_PARITY : ST_STOP;
          end
        end
        ST_PARITY: begin
          cnt <= cnt + 1'b1;
          if (atEnd) state <= ST_STOP;
        end
        ST_STOP: begin
          cnt <= cnt + 1'b1;
          if (atEnd) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/serial_rx_dpath.sv
module serial_rx_dpath
  import serial_rx_pkg::*;
#(
  parameter int DW   = 8,
  parameter int SYNC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  rxStrobe_t     strobe,
  input  logic          serialIn,
  input  logic [1:0]    paritySel,
  input  logic          charLen8,
  input  logic          errToComplete,
  input  logic          bufRead,
  output logic          rxBit,
  output logic [DW-1:0] rxData,
  output logic          doneIrq,
  output logic          errIrq,
  output logic          parityErr,
  output logic          frameErr,
  output logic          overrunErr
);

  logic [SYNC-1:0] syncReg;
  logic [DW-1:0]   shiftReg;
  logic            parBit;
  logic            unread;
  logic [DW-1:0]   dataNow;
  logic            parMismatch;
  logic            pErr;
  logic            fErr;
  logic            oErr;
  logic            anyErr;

  // input synchronizer, idle level is high
  always_ff @(posedge clk) begin
    if (!rst_n) syncReg <= '1;
    else        syncReg <= {syncReg[SYNC-2:0], serialIn};
  end
  assign rxBit = syncReg[SYNC-1];

  always_ff @(posedge clk) begin
    if (!rst_n || strobe.clear) begin
      shiftReg <= '0;
      parBit   <= 1'b0;
    end else begin
      if (strobe.shift)    shiftReg <= {rxBit, shiftReg[DW-1:1]};
      if (strobe.parLatch) parBit   <= rxBit;
    end
  end

  assign dataNow     = charLen8 ? shiftReg : {1'b0, shiftReg[DW-1:1]};
  assign parMismatch = ^{dataNow, parBit};
  always_comb begin
    unique case (paritySel)
      2'b10:   pErr = !parMismatch;
      2'b11:   pErr = parMismatch;
      default: pErr = 1'b0;
    endcase
  end
  assign fErr   = !rxBit;
  assign oErr   = unread && !bufRead;
  assign anyErr = pErr || fErr || oErr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rxData     <= '0;
      doneIrq    <= 1'b0;
      errIrq     <= 1'b0;
      parityErr  <= 1'b0;
      frameErr   <= 1'b0;
      overrunErr <= 1'b0;
      unread     <= 1'b0;
    end else begin
      doneIrq <= strobe.commit && (!anyErr || errToComplete);
      errIrq  <= strobe.commit && anyErr && !errToComplete;
      if (strobe.commit) begin
        rxData     <= dataNow;
        parityErr  <= pErr;
        frameErr   <= fErr;
        overrunErr <= oErr;
        unread     <= 1'b1;
      end else if (bufRead) begin
        unread <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/serial_rx.sv
module serial_rx
  import serial_rx_pkg::*;
#(
  parameter int OVS = 16,
  parameter int DW  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rxEnable,
  input  logic [1:0]    paritySel,
  input  logic          charLen8,
  input  logic          errToComplete,
  input  logic          sampleTick,
  input  logic          serialIn,
  input  logic          bufRead,
  output logic [DW-1:0] rxData,
  output logic          doneIrq,
  output logic          errIrq,
  output logic          parityErr,
  output logic          frameErr,
  output logic          overrunErr
);

  rxStrobe_t strobe;
  logic      rxBit;

  serial_rx_ctrl #(.OVS(OVS), .DW(DW)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (rxEnable),
    .tick     (sampleTick),
    .rxBit    (rxBit),
    .charLen8 (charLen8),
    .parityOn (paritySel != 2'b00),
    .strobe   (strobe)
  );

  serial_rx_dpath #(.DW(DW), .SYNC(2)) u_dpath (
    .clk           (clk),
    .rst_n         (rst_n),
    .strobe        (strobe),
    .serialIn      (serialIn),
    .paritySel     (paritySel),
    .charLen8      (charLen8),
    .errToComplete (errToComplete),
    .bufRead       (bufRead),
    .rxBit         (rxBit),
    .rxData        (rxData),
    .doneIrq       (doneIrq),
    .errIrq        (errIrq),
    .parityErr     (parityErr),
    .frameErr      (frameErr),
    .overrunErr    (overrunErr)
  );

endmodule

// File: rtl/serial_rx_chk.sv
module serial_rx_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rxEnable,
  input logic [1:0]    paritySel,
  input logic          charLen8,
  input logic          errToComplete,
  input logic [DW-1:0] rxData,
  input logic          doneIrq,
  input logic          errIrq,
  input logic          parityErr
);

  a_r1_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !rxEnable |=> ($stable(rxData) && !doneIrq && !errIrq));

  a_r4_short_char_msb: assert property (@(posedge clk) disable iff (!rst_n)
    (doneIrq || errIrq) && !charLen8 |-> !rxData[DW-1]);

  a_r5_zero_parity_unchecked: assert property (@(posedge clk) disable iff (!rst_n)
    (doneIrq || errIrq) && paritySel == 2'b01 |-> !parityErr);

  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    doneIrq |=> !doneIrq);

  a_r9_never_both: assert property (@(posedge clk) disable iff (!rst_n)
    !(doneIrq && errIrq));

  a_r10_no_err_irq_routed: assert property (@(posedge clk) disable iff (!rst_n)
    errIrq |-> !errToComplete);

endmodule

bind serial_rx serial_rx_chk #(.DW(DW)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .rxEnable      (rxEnable),
  .paritySel     (paritySel),
  .charLen8      (charLen8),
  .errToComplete (errToComplete),
  .rxData        (rxData),
  .doneIrq       (doneIrq),
  .errIrq        (errIrq),
  .parityErr     (parityErr)
);

// File: tb/serial_rx_bench.sv
module serial_rx_bench;

  localparam int BITCLK = 64;  // 16 ticks of 4 clocks
  localparam int VW = 26;
  localparam int NV = 7;
  // {data, len8, psel, route, badPar, stop, expData, expDone, expErr, expPE, expFE}
  localparam logic [VW-1:0] VEC [NV] = '{
    {8'hA5, 1'b1, 2'b00, 1'b0, 1'b0, 1'b1, 8'hA5, 1'b1, 1'b0, 1'b0, 1'b0},
    {8'hD3, 1'b0, 2'b00, 1'b0, 1'b0, 1'b1, 8'h53, 1'b1, 1'b0, 1'b0, 1'b0},
    {8'h3C, 1'b1, 2'b10, 1'b0, 1'b0, 1'b1, 8'h3C, 1'b1, 1'b0, 1'b0, 1'b0},
    {8'h3C, 1'b1, 2'b11, 1'b0, 1'b1, 1'b1, 8'h3C, 1'b0, 1'b1, 1'b1, 1'b0},
    {8'h81, 1'b1, 2'b01, 1'b0, 1'b1, 1'b1, 8'h81, 1'b1, 1'b0, 1'b0, 1'b0},
    {8'h5A, 1'b1, 2'b00, 1'b1, 1'b0, 1'b0, 8'h5A, 1'b1, 1'b0, 1'b0, 1'b1},
    {8'h7F, 1'b0, 2'b11, 1'b0, 1'b0, 1'b1, 8'h7F, 1'b1, 1'b0, 1'b0, 1'b0}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rxEnable = 1'b0;
  logic [1:0] paritySel = 2'b00;
  logic       charLen8 = 1'b1;
  logic       errToComplete = 1'b0;
  logic       sampleTick = 1'b0;
  logic       serialIn = 1'b1;
  logic       bufRead = 1'b0;
  logic [7:0] rxData;
  logic       doneIrq, errIrq, parityErr, frameErr, overrunErr;

  int checks = 0;
  int errors = 0;
  int doneCnt = 0;
  int errCnt = 0;
  logic [1:0] tickDiv = 2'd0;
  logic finished = 1'b0;

  always #10 clk = ~clk;

  always @(posedge clk) begin
    tickDiv    <= tickDiv + 2'd1;
    sampleTick <= (tickDiv == 2'd3);
    if (doneIrq) doneCnt <= doneCnt + 1;
    if (errIrq)  errCnt  <= errCnt + 1;
  end

  serial_rx u_serial_rx (
    .clk(clk), .rst_n(rst_n), .rxEnable(rxEnable), .paritySel(paritySel),
    .charLen8(charLen8), .errToComplete(errToComplete), .sampleTick(sampleTick),
    .serialIn(serialIn), .bufRead(bufRead), .rxData(rxData), .doneIrq(doneIrq),
    .errIrq(errIrq), .parityErr(parityErr), .frameErr(frameErr), .overrunErr(overrunErr)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic sendBit(input logic v);
    @(negedge clk) serialIn = v;
    repeat (BITCLK - 1) @(negedge clk);
  endtask

  task automatic sendFrame(input logic [7:0] d, input logic len8, input logic [1:0] ps,
                           input logic badPar, input logic stopV);
    logic [7:0] dm;
    logic pb;
    dm = len8 ? d : {1'b0, d[6:0]};
    sendBit(1'b0);
    for (int i = 0; i < (len8 ? 8 : 7); i++) sendBit(d[i]);
    if (ps != 2'b00) begin
      pb = (ps == 2'b10) ? ~^dm : (ps == 2'b11) ? ^dm : 1'b1;
      sendBit(pb ^ badPar);
    end
    sendBit(stopV);
    sendBit(1'b1);
  endtask

  task automatic readBuf();
    @(negedge clk) bufRead = 1'b1;
    @(negedge clk) bufRead = 1'b0;
  endtask

  task automatic clearCounts();
    @(negedge clk);
    doneCnt = 0;
    errCnt = 0;
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R7 reset state
    check("R7 reset data", rxData, 8'h00);
    check("R7 reset irqs", {doneIrq, errIrq}, 2'b00);
    check("R7 reset flags", {parityErr, frameErr, overrunErr}, 3'b000);

    // R1: disabled, frame ignored
    clearCounts();
    sendFrame(8'h12, 1'b1, 2'b00, 1'b0, 1'b1);
    check("R1 no irq while off", doneCnt + errCnt, 0);
    check("R1 buffer retained", rxData, 8'h00);

    rxEnable = 1'b1;
    repeat (BITCLK) @(negedge clk);

    // table walk: R3 R4 R5 R6 R7 R9 R10
    for (int v = 0; v < NV; v++) begin
      logic [VW-1:0] e;
      e = VEC[v];
      charLen8 = e[17];
      paritySel = e[16:15];
      errToComplete = e[14];
      clearCounts();
      sendFrame(e[25:18], e[17], e[16:15], e[13], e[12]);
      check($sformatf("R3/R4 vec%0d data", v), rxData, e[11:4]);
      check($sformatf("R9/R10 vec%0d doneIrq count", v), doneCnt, e[3]);
      check($sformatf("R9/R10 vec%0d errIrq count", v), errCnt, e[2]);
      check($sformatf("R5 vec%0d parityErr", v), parityErr, e[1]);
      check($sformatf("R6 vec%0d frameErr", v), frameErr, e[0]);
      check($sformatf("R8 vec%0d no overrun", v), overrunErr, 1'b0);
      readBuf();
    end

    charLen8 = 1'b1;
    paritySel = 2'b00;
    errToComplete = 1'b0;

    // R2: glitch two ticks wide is rejected
    clearCounts();
    @(negedge clk) serialIn = 1'b0;
    repeat (8) @(negedge clk);
    serialIn = 1'b1;
    repeat (4 * BITCLK) @(negedge clk);
    check("R2 glitch gives no irq", doneCnt + errCnt, 0);
    check("R2 glitch leaves buffer", rxData, 8'h7F);
    sendFrame(8'h66, 1'b1, 2'b00, 1'b0, 1'b1);
    check("R2 frame after glitch", rxData, 8'h66);
    check("R2 one completion", doneCnt, 1);
    readBuf();

    // R8 overrun, routed to completion (R10)
    errToComplete = 1'b1;
    clearCounts();
    sendFrame(8'h11, 1'b1, 2'b00, 1'b0, 1'b1);
    sendFrame(8'h22, 1'b1, 2'b00, 1'b0, 1'b1);
    check("R8 overrun set", overrunErr, 1'b1);
    check("R8 overrun data", rxData, 8'h22);
    check("R10 overrun to doneIrq", {doneCnt[3:0], errCnt[3:0]}, {4'd2, 4'd0});
    readBuf();
    sendFrame(8'h33, 1'b1, 2'b00, 1'b0, 1'b1);
    check("R8 overrun cleared after read", overrunErr, 1'b0);
    readBuf();

    // R9: overrun routed to error irq
    errToComplete = 1'b0;
    sendFrame(8'h44, 1'b1, 2'b00, 1'b0, 1'b1);
    clearCounts();
    sendFrame(8'h55, 1'b1, 2'b00, 1'b0, 1'b1);
    check("R9 overrun only errIrq", {doneCnt[3:0], errCnt[3:0]}, {4'd0, 4'd1});
    readBuf();

    // R11: abandon partial frame by short disable
    clearCounts();
    sendBit(1'b0);
    sendBit(1'b1);
    sendBit(1'b0);
    @(negedge clk) rxEnable = 1'b0;
    serialIn = 1'b1;
    repeat (3) @(negedge clk);
    rxEnable = 1'b1;
    repeat (BITCLK) @(negedge clk);
    check("R11 partial frame dropped", doneCnt + errCnt, 0);
    sendFrame(8'h4B, 1'b1, 2'b00, 1'b0, 1'b1);
    check("R11 clean frame data", rxData, 8'h4B);
    check("R11 single completion", {doneCnt[3:0], errCnt[3:0]}, {4'd1, 4'd0});
    check("R11 no framing error", frameErr, 1'b0);

    finishRun();
  end

endmodule